// File: doc/BRIEF.md
# Prioritized Interrupt Entry Sequencer

This block performs the hardware side of taking an interrupt on an 8-bit processor whose stack lives in a fixed 256-byte page. At an instruction boundary the executor pulses a start strobe. The block then looks at its latched requests and picks one of three kinds: a reset request, a non-maskable request, or a maskable request. The maskable request is formed from two sources ORed together and is gated by the processor's interrupt-disable flag.

For the two interrupt kinds, the block saves the program counter and a packed status byte on the stack through a byte-wide memory port. It then signals that the interrupt-disable flag must be set. Next it reads a two-byte vector, low byte first, and hands the new program counter back with a one-cycle load pulse. A reset entry skips the stack and sets the stack pointer to its top. The block owns the stack pointer. The executor owns the other processor flags and supplies them as inputs.

The non-maskable input is edge sensitive. A rising edge leaves a pending request behind. Taking the interrupt consumes that request, and holding the line high produces no further requests.

Top module: `irq_entry_seq`

## Requirements
- R1: A start pulse while idle selects, from the requests latched before that clock edge, a reset request over a non-maskable request over a maskable request. The chosen kind is shown on `entry_kind` during the sequence with the encoding 1 = reset, 2 = non-maskable, 3 = maskable.
- R2: The maskable request is `irq_a | irq_b`. It is taken only when `flag_i` is 0. A start with nothing eligible starts no sequence: `busy` and `done` stay 0.
- R3: A rising edge on `nmi_line` latches a non-maskable request. Keeping the line high creates no further request. The request is cleared when a non-maskable entry is taken.
- R4: A non-maskable or maskable entry makes exactly three writes, in this order: the program-counter high byte, the low byte, then the status byte. Each write goes to address `0x01 << 8 | sp`, and `sp` is decremented by one after each write (modulo 256).
- R5: The pushed status byte is {N, V, 1, 0, D, I, Z, C} from bit 7 down to bit 0, using the flag inputs as sampled with the start pulse.
- R6: `i_set` pulses for one cycle after the last push (or directly, for a reset entry). It comes two cycles before `done`, in the cycle in which the low vector byte is read.
- R7: The vector is read from 0xFFFC (reset), 0xFFFA (non-maskable) or 0xFFFE (maskable), low byte first, then the next address. Read data is returned by the memory one cycle after `mem_re`. `pc_out` equals {high, low} while `pc_load` is 1.
- R8: `done` and `pc_load` are single-cycle pulses. Counting the start cycle as the first, they occur in cycle 7 for non-maskable and maskable entries and in cycle 4 for a reset entry.
- R9: After `rst_n` the stack pointer is 0xFF, the block is idle, and a reset request is pending. A reset entry makes no writes, sets `sp` to 0xFF and clears any pending non-maskable request.
- R10: A start pulse while `busy` is 1 is ignored. It does not change the running sequence and does not start another one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Instruction-boundary strobe |
| reset_req | input | 1 | Soft reset request pulse |
| nmi_line | input | 1 | Non-maskable request line, edge sensitive |
| irq_a | input | 1 | Maskable source A (level) |
| irq_b | input | 1 | Maskable source B (level) |
| flag_n | input | 1 | Negative flag from executor |
| flag_v | input | 1 | Overflow flag from executor |
| flag_d | input | 1 | Decimal flag from executor |
| flag_i | input | 1 | Interrupt-disable flag from executor |
| flag_z | input | 1 | Zero flag from executor |
| flag_c | input | 1 | Carry flag from executor |
| pc_in | input | 16 | Program counter to save |
| mem_rdata | input | 8 | Memory read data, one cycle after mem_re |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| pc_out | output | 16 | New program counter |
| pc_load | output | 1 | Load pulse for pc_out |
| i_set | output | 1 | Pulse telling the executor to set the interrupt-disable flag |
| sp | output | 8 | Stack pointer |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | End-of-sequence pulse |
| entry_kind | output | 2 | Kind being taken (0 when idle) |

## Verification
The checker covers the following on every cycle:
- every write lands in the stack page and is followed by a one-step decrement of the stack pointer;
- reads and writes never overlap;
- `done` never lasts two cycles;
- a load is always preceded by a read;
- a taken maskable request always had its mask clear and a live source;
- a taken non-maskable request is cleared;
- no entry is accepted while busy.

The bench's scenarios cover what the checker does not see: the order and contents of the three pushes, the packed status layout, the vector chosen for each kind, and the cycle on which `done` arrives. The same holds for the priority among simultaneous requests, the fact that a held non-maskable line raises no second request, the clearing of a pending non-maskable request by a reset entry, and stack pointer wrap across many entries.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  typedef enum logic [1:0] {
    K_NONE = 2'd0,
    K_RST  = 2'd1,
    K_NMI  = 2'd2,
    K_IRQ  = 2'd3
  } entry_kind_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PUSH_H,
    S_PUSH_L,
    S_PUSH_P,
    S_VEC_L,
    S_VEC_H,
    S_LOAD
  } seq_state_t;

  // Status byte layout: N V 1 B D I Z C, B forced to 0 for hardware entry
  function automatic logic [7:0] pack_status(input logic n, input logic v,
                                             input logic d, input logic i,
                                             input logic z, input logic c);
    return {n, v, 1'b1, 1'b0, d, i, z, c};
  endfunction

endpackage

// File: rtl/irq_pend.sv
module irq_pend
  import irq_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reset_req,
  input  logic        nmi_line,
  input  logic        irq_a,
  input  logic        irq_b,
  input  logic        flag_i,
  input  logic        take,
  output entry_kind_t sel_kind,
  output logic        nmi_edge,
  output logic        nmi_pend,
  output logic        rst_pend
);

  logic nmi_q;
  logic clr_rst;
  logic clr_nmi;

  assign nmi_edge = nmi_line & ~nmi_q;
  assign clr_rst  = take && (sel_kind == K_RST);
  assign clr_nmi  = take && (sel_kind == K_RST || sel_kind == K_NMI);

  always_comb begin
    if (rst_pend)                      sel_kind = K_RST;
    else if (nmi_pend)                 sel_kind = K_NMI;
    else if ((irq_a | irq_b) && !flag_i) sel_kind = K_IRQ;
    else                               sel_kind = K_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nmi_q    <= 1'b1;
      nmi_pend <= 1'b0;
      rst_pend <= 1'b1;
    end else begin
      nmi_q    <= nmi_line;
      rst_pend <= reset_req | (rst_pend & ~clr_rst);
      nmi_pend <= nmi_edge  | (nmi_pend & ~clr_nmi);
    end
  end

endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
  import irq_seq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] STACK_PAGE = 8'h01,
  parameter logic [2*DATA_W-1:0] VEC_RST = 16'hFFFC,
  parameter logic [2*DATA_W-1:0] VEC_NMI = 16'hFFFA,
  parameter logic [2*DATA_W-1:0] VEC_IRQ = 16'hFFFE,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  entry_kind_t       kind_in,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [7:0]        status_in,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  output logic [ADDR_W-1:0] pc_out,
  output logic              pc_load,
  output logic              i_set,
  output logic [DATA_W-1:0] sp,
  output logic              busy,
  output logic              done,
  output entry_kind_t       entry_kind
);

  seq_state_t        state;
  entry_kind_t       kind_q;
  logic [ADDR_W-1:0] pc_q;
  logic [7:0]        stat_q;
  logic [DATA_W-1:0] lo_q;
  logic [DATA_W-1:0] sp_q;
  logic [ADDR_W-1:0] vec;

  function automatic logic [ADDR_W-1:0] vector_of(input entry_kind_t k);
    case (k)
      K_RST:   return VEC_RST;
      K_NMI:   return VEC_NMI;
      default: return VEC_IRQ;
    endcase
  endfunction

  assign vec = vector_of(kind_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      kind_q <= K_NONE;
      pc_q   <= '0;
      stat_q <= '0;
      lo_q   <= '0;
      sp_q   <= '1;
    end else begin
      case (state)
        S_IDLE: if (take) begin
          kind_q <= kind_in;
          pc_q   <= pc_in;
          stat_q <= status_in;
          if (kind_in == K_RST) begin
            sp_q  <= '1;
            state <= S_VEC_L;
          end else begin
            state <= S_PUSH_H;
          end
        end
        S_PUSH_H: begin sp_q <= sp_q - 1'b1; state <= S_PUSH_L; end
        S_PUSH_L: begin sp_q <= sp_q - 1'b1; state <= S_PUSH_P; end
        S_PUSH_P: begin sp_q <= sp_q - 1'b1; state <= S_VEC_L;  end
        S_VEC_L:  state <= S_VEC_H;
        S_VEC_H:  begin lo_q <= mem_rdata; state <= S_LOAD; end
        S_LOAD:   begin kind_q <= K_NONE; state <= S_IDLE; end
        default:  state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_addr  = '0;
    mem_wdata = '0;
    case (state)
      S_PUSH_H: begin mem_addr = {STACK_PAGE, sp_q}; mem_wdata = pc_q[ADDR_W-1:DATA_W]; end
      S_PUSH_L: begin mem_addr = {STACK_PAGE, sp_q}; mem_wdata = pc_q[DATA_W-1:0]; end
      S_PUSH_P: begin mem_addr = {STACK_PAGE, sp_q}; mem_wdata = stat_q[DATA_W-1:0]; end
      S_VEC_L:  mem_addr = vec;
      S_VEC_H:  mem_addr = vec + 1'b1;
      default:  ;
    endcase
  end

  assign mem_we     = (state == S_PUSH_H) || (state == S_PUSH_L) || (state == S_PUSH_P);
  assign mem_re     = (state == S_VEC_L) || (state == S_VEC_H);
  assign i_set      = (state == S_VEC_L);
  assign done       = (state == S_LOAD);
  assign pc_load    = (state == S_LOAD);
  assign pc_out     = (state == S_LOAD) ? {mem_rdata, lo_q} : pc_q;
  assign busy       = (state != S_IDLE);
  assign sp         = sp_q;
  assign entry_kind = kind_q;

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] STACK_PAGE = 8'h01,
  parameter logic [2*DATA_W-1:0] VEC_RST = 16'hFFFC,
  parameter logic [2*DATA_W-1:0] VEC_NMI = 16'hFFFA,
  parameter logic [2*DATA_W-1:0] VEC_IRQ = 16'hFFFE,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              reset_req,
  input  logic              nmi_line,
  input  logic              irq_a,
  input  logic              irq_b,
  input  logic              flag_n,
  input  logic              flag_v,
  input  logic              flag_d,
  input  logic              flag_i,
  input  logic              flag_z,
  input  logic              flag_c,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  output logic [ADDR_W-1:0] pc_out,
  output logic              pc_load,
  output logic              i_set,
  output logic [DATA_W-1:0] sp,
  output logic              busy,
  output logic              done,
  output logic [1:0]        entry_kind
);

  entry_kind_t sel_kind;
  entry_kind_t kind_q;
  logic        take;
  logic        nmi_edge;
  logic        nmi_pend;
  logic        rst_pend;
  logic [7:0]  status_w;

  assign take       = start && !busy && (sel_kind != K_NONE);
  assign status_w   = pack_status(flag_n, flag_v, flag_d, flag_i, flag_z, flag_c);
  assign entry_kind = kind_q;

  irq_pend u_pend (
    .clk       (clk),
    .rst_n     (rst_n),
    .reset_req (reset_req),
    .nmi_line  (nmi_line),
    .irq_a     (irq_a),
    .irq_b     (irq_b),
    .flag_i    (flag_i),
    .take      (take),
    .sel_kind  (sel_kind),
    .nmi_edge  (nmi_edge),
    .nmi_pend  (nmi_pend),
    .rst_pend  (rst_pend)
  );

  irq_seq_fsm #(
    .DATA_W     (DATA_W),
    .STACK_PAGE (STACK_PAGE),
    .VEC_RST    (VEC_RST),
    .VEC_NMI    (VEC_NMI),
    .VEC_IRQ    (VEC_IRQ)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (take),
    .kind_in    (sel_kind),
    .pc_in      (pc_in),
    .status_in  (status_w),
    .mem_rdata  (mem_rdata),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_we     (mem_we),
    .mem_re     (mem_re),
    .pc_out     (pc_out),
    .pc_load    (pc_load),
    .i_set      (i_set),
    .sp         (sp),
    .busy       (busy),
    .done       (done),
    .entry_kind (kind_q)
  );

endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk
  import irq_seq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] STACK_PAGE = 8'h01,
  localparam int ADDR_W = 2 * DATA_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              take,
  input entry_kind_t       sel_kind,
  input logic              nmi_edge,
  input logic              nmi_pend,
  input logic              rst_pend,
  input logic              irq_a,
  input logic              irq_b,
  input logic              flag_i,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_we,
  input logic              mem_re,
  input logic              pc_load,
  input logic              done,
  input logic              i_set,
  input logic [DATA_W-1:0] sp,
  input logic [1:0]        entry_kind
);

  a_r4_push_in_stack: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_addr[ADDR_W-1:DATA_W] == STACK_PAGE);

  a_r4_sp_step: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> sp == $past(sp) - 1'b1);

  a_r4_no_rw_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_load_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> $past(mem_re));

  a_r6_iset_after_push: assert property (@(posedge clk) disable iff (!rst_n)
    (i_set && entry_kind != K_RST) |-> $past(mem_we));

  a_r2_irq_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (take && sel_kind == K_IRQ) |-> (!flag_i && (irq_a || irq_b)));

  a_r3_nmi_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (take && sel_kind == K_NMI && !nmi_edge) |=> !nmi_pend);

  a_r10_no_take_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !take);

  a_r1_reset_first: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && rst_pend) |-> take && sel_kind == K_RST);

  a_r9_rst_sp_top: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load && entry_kind == K_RST) |-> sp == '1);

endmodule

bind irq_entry_seq irq_entry_seq_chk #(
  .DATA_W     (DATA_W),
  .STACK_PAGE (STACK_PAGE)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .busy       (busy),
  .take       (take),
  .sel_kind   (sel_kind),
  .nmi_edge   (nmi_edge),
  .nmi_pend   (nmi_pend),
  .rst_pend   (rst_pend),
  .irq_a      (irq_a),
  .irq_b      (irq_b),
  .flag_i     (flag_i),
  .mem_addr   (mem_addr),
  .mem_we     (mem_we),
  .mem_re     (mem_re),
  .pc_load    (pc_load),
  .done       (done),
  .i_set      (i_set),
  .sp         (sp),
  .entry_kind (entry_kind)
);

// File: tb/test_irq_entry_seq.sv
module test_irq_entry_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        reset_req = 1'b0;
  logic        nmi_line = 1'b0;
  logic        irq_a = 1'b0;
  logic        irq_b = 1'b0;
  logic        flag_n = 1'b0, flag_v = 1'b0, flag_d = 1'b0;
  logic        flag_i = 1'b1, flag_z = 1'b0, flag_c = 1'b0;
  logic [15:0] pc_in = 16'h0000;
  logic [7:0]  mem_rdata = 8'h00;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_we, mem_re;
  logic [15:0] pc_out;
  logic        pc_load, i_set;
  logic [7:0]  sp;
  logic        busy, done;
  logic [1:0]  entry_kind;

  int n_chk = 0;
  int n_err = 0;

  // bench model
  bit         m_rst;
  bit         m_nmi;
  logic [7:0] m_sp;
  logic [7:0] vecmem [6];

  always #4 clk = ~clk;

  irq_entry_seq i_irq_entry_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .reset_req(reset_req),
    .nmi_line(nmi_line), .irq_a(irq_a), .irq_b(irq_b),
    .flag_n(flag_n), .flag_v(flag_v), .flag_d(flag_d),
    .flag_i(flag_i), .flag_z(flag_z), .flag_c(flag_c),
    .pc_in(pc_in), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .pc_out(pc_out), .pc_load(pc_load), .i_set(i_set), .sp(sp),
    .busy(busy), .done(done), .entry_kind(entry_kind)
  );

  // synchronous memory: data one cycle after the read strobe
  always @(posedge clk) begin
    if (mem_re && mem_addr >= 16'hFFFA) mem_rdata <= vecmem[int'(mem_addr - 16'hFFFA)];
    else                                mem_rdata <= 8'hEE;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_status(input logic n, v, d, i, z, c);
    int s;
    s = 32 + (n ? 128 : 0) + (v ? 64 : 0) + (d ? 8 : 0) + (i ? 4 : 0) + (z ? 2 : 0) + (c ? 1 : 0);
    return s[7:0];
  endfunction

  function automatic logic [1:0] exp_kind();
    if (m_rst) return 2'd1;
    if (m_nmi) return 2'd2;
    if ((irq_a || irq_b) && !flag_i) return 2'd3;
    return 2'd0;
  endfunction

  function automatic int vec_index(input logic [1:0] k);
    if (k == 2'd1) return 2;
    if (k == 2'd2) return 0;
    return 4;
  endfunction

  task automatic set_nmi(input bit v);
    @(negedge clk);
    if (v && !nmi_line) m_nmi = 1;
    nmi_line = v;
    @(negedge clk);
  endtask

  task automatic pulse_reset();
    @(negedge clk);
    reset_req = 1'b1;
    @(negedge clk);
    reset_req = 1'b0;
    m_rst = 1;
  endtask

  task automatic run_start(input bit poke);
    logic [1:0]  ek;
    logic [15:0] pc;
    logic [7:0]  st;
    logic [15:0] waddr [4];
    logic [7:0]  wdat  [4];
    int          nw, iset_at, done_at, vi;
    logic [15:0] pc_got;
    logic [1:0]  kind_got;
    logic [7:0]  sp_got;
    ek = exp_kind();
    pc = pc_in;
    st = exp_status(flag_n, flag_v, flag_d, flag_i, flag_z, flag_c);
    nw = 0; iset_at = 0; done_at = 0; pc_got = '0; kind_got = '0; sp_got = '0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (ek == 2'd0) begin
      for (int k = 0; k < 3; k++) begin
        chk("R2 no entry busy", {31'd0, busy}, 32'd0);
        chk("R2 no entry done", {31'd0, done}, 32'd0);
        @(negedge clk);
      end
      return;
    end
    for (int cyc = 1; cyc <= 12; cyc++) begin
      if (mem_we && nw < 4) begin waddr[nw] = mem_addr; wdat[nw] = mem_wdata; end
      if (mem_we) nw++;
      if (i_set) iset_at = cyc;
      if (done) begin
        done_at = cyc; pc_got = pc_out; kind_got = entry_kind; sp_got = sp;
        if (!pc_load) chk("R8 pc_load with done", 32'd0, 32'd1);
        break;
      end
      @(negedge clk);
      start = (poke && cyc == 1) ? 1'b1 : 1'b0;
    end
    start = 1'b0;
    chk("R1 kind", {30'd0, kind_got}, {30'd0, ek});
    chk("R8 done cycle", done_at, (ek == 2'd1) ? 3 : 6);
    chk("R6 i_set cycle", iset_at, done_at - 2);
    vi = vec_index(ek);
    chk("R7 pc_out", {16'd0, pc_got}, {16'd0, vecmem[vi+1], vecmem[vi]});
    if (ek == 2'd1) begin
      chk("R9 no pushes", nw, 0);
      m_sp = 8'hFF;
      m_rst = 0;
      m_nmi = 0;
    end else begin
      chk("R4 push count", nw, 3);
      chk("R4 addr hi", {16'd0, waddr[0]}, {16'd0, 8'h01, m_sp});
      chk("R4 addr lo", {16'd0, waddr[1]}, {16'd0, 8'h01, m_sp - 8'd1});
      chk("R4 addr st", {16'd0, waddr[2]}, {16'd0, 8'h01, m_sp - 8'd2});
      chk("R4 pc hi",   {24'd0, wdat[0]}, {24'd0, pc[15:8]});
      chk("R4 pc lo",   {24'd0, wdat[1]}, {24'd0, pc[7:0]});
      chk("R5 status",  {24'd0, wdat[2]}, {24'd0, st});
      m_sp = m_sp - 8'd3;
      if (ek == 2'd2) m_nmi = 0;
    end
    chk("R4 sp after", {24'd0, sp_got}, {24'd0, m_sp});
    @(negedge clk);
    chk("R8 done single", {31'd0, done}, 32'd0);
    chk("R10 idle after", {31'd0, busy}, 32'd0);
  endtask

  task automatic rand_flags();
    flag_n = 1'($urandom); flag_v = 1'($urandom); flag_d = 1'($urandom);
    flag_z = 1'($urandom); flag_c = 1'($urandom);
    pc_in  = 16'($urandom);
  endtask

  initial begin
    #(8 * 150000);
    n_err++;
    n_chk++;
    $display("FAIL R8 watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int k = 0; k < 6; k++) vecmem[k] = 8'($urandom);
    m_rst = 1; m_nmi = 0; m_sp = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 reset sp", {24'd0, sp}, 32'hFF);
    chk("R9 reset busy", {31'd0, busy}, 32'd0);
    chk("R9 reset done", {31'd0, done}, 32'd0);
    chk("R9 reset we", {31'd0, mem_we}, 32'd0);

    // R9: pending reset request after rst_n
    rand_flags();
    run_start(0);

    // R2: masked request ignored, then taken from either source
    flag_i = 1; irq_a = 1; rand_flags();
    run_start(0);
    flag_i = 0;
    run_start(0);
    irq_a = 0; irq_b = 1; rand_flags();
    run_start(0);
    irq_b = 0;

    // R1: non-maskable beats maskable
    irq_a = 1; set_nmi(1); rand_flags();
    run_start(0);
    irq_a = 0;
    // R3: line still high, no new request
    run_start(0);
    set_nmi(0); set_nmi(1); rand_flags();
    run_start(0);
    set_nmi(0);

    // R9: reset wins and clears a pending non-maskable request
    set_nmi(1); pulse_reset(); rand_flags();
    run_start(0);
    run_start(0);
    set_nmi(0);

    // R10: start during a sequence is ignored
    flag_i = 0; irq_b = 1; rand_flags();
    run_start(1);
    irq_b = 0;

    // random mix
    for (int it = 0; it < 400; it++) begin
      for (int k = 0; k < 6; k++) vecmem[k] = 8'($urandom);
      if ($urandom_range(0, 15) == 0) pulse_reset();
      if ($urandom_range(0, 2) == 0) set_nmi(1'($urandom));
      irq_a  = ($urandom_range(0, 2) == 0);
      irq_b  = ($urandom_range(0, 3) == 0);
      flag_i = 1'($urandom);
      rand_flags();
      @(negedge clk);
      run_start($urandom_range(0, 3) == 0);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule